// File: doc/BRIEF.md
# Trace Capture Buffer with Stall Control

This block holds watchpoint-hit trace entries in a first-in first-out buffer until a downstream consumer drains them through a valid/ready read port. A one-bit mode field in a memory-mapped control register decides what happens as the buffer fills. In discard mode the buffer takes entries until every slot is used and then drops further hits, counting each one. In stall mode the block raises a CPU stall request once occupancy reaches an almost-full threshold. The slots above that threshold take the entries that still arrive while the CPU reacts.

The same control register has a read-only status bit. It reads 1 while the buffer holds the CPU stalled or while an external suspend input is high. A second register offset returns a saturating count of dropped hits. The register port is a single-cycle bus: address, write enable and write data go in, and read data comes back combinationally.

Top module: `trace_capture_buf`

## Requirements
- R1: After reset the mode bit is 0, the status bit is 0, the stall request is low, the read port shows no valid entry and the drop count reads 0.
- R2: The register at word offset 0 holds the mode at bit 8 (0 = discard, 1 = stall). A write there updates it and a read returns it. A write to any other offset leaves it unchanged.
- R3: In discard mode the stall request is never asserted. A hit is stored while fewer than DEPTH entries are held, and is dropped when the buffer is full and no read happens in that cycle.
- R4: In stall mode the stall request is high in every cycle in which occupancy is at least DEPTH-MARGIN, and low whenever occupancy is below it.
- R5: In stall mode, hits that arrive after the stall request, while occupancy is from DEPTH-MARGIN up to DEPTH-1, are stored and not dropped.
- R6: Bit 9 of the register at offset 0 reads (stall request OR suspend input). Writes to bit 9 have no effect. All other bits of that register read 0.
- R7: The read port presents the oldest held entry with the valid signal high whenever the buffer is not empty. A cycle with valid and ready both high removes that entry, so entries leave in arrival order.
- R8: When the buffer is full, a hit and a read in the same cycle are both accepted, and the drop count does not change.
- R9: The register at word offset 1 returns the drop count in its low DROP_W bits, with the rest 0. The count grows by one for each dropped hit and stays at 2^DROP_W-1 once it reaches that value. Any other offset reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hard reset |
| hit_valid | input | 1 | A watchpoint-hit entry is offered this cycle |
| hit_data | input | ENTRY_W | Trace entry content |
| rd_valid | output | 1 | Buffer holds at least one entry |
| rd_ready | input | 1 | Consumer takes the presented entry |
| rd_data | output | ENTRY_W | Oldest held entry |
| cpu_stall_req | output | 1 | Stall request to the CPU |
| suspend_in | input | 1 | CPU suspended by the watchpoint controller |
| bus_addr | input | ADDR_W | Register word address |
| bus_we | input | 1 | Register write strobe |
| bus_wdata | input | BUS_W | Register write data |
| bus_rdata | output | BUS_W | Register read data |

## Verification
The bench builds the block with DEPTH 8, MARGIN 3 and DROP_W 4. With these values the stall threshold is five entries and true full is eight, both reached within a few cycles. Sixteen drops are enough to saturate the counter, so the saturation case of R9 can be driven directly. A 16-bit entry width gives distinct, random patterns for checking arrival order. Because the buffer is shallow, random hit and drain rates cross the threshold and the full boundary many times in both modes.

// File: rtl/trc_pkg.sv
package trc_pkg;
   typedef enum logic {
      MODE_DISCARD = 1'b0,
      MODE_STALL   = 1'b1
   } buf_mode_e;

   localparam int MODE_BIT = 8;
   localparam int STAT_BIT = 9;
endpackage

// File: rtl/trc_fifo.sv
module trc_fifo #(
   parameter int ENTRY_W = 32,
   parameter int DEPTH   = 16,
   localparam int PTR_W  = $clog2(DEPTH),
   localparam int CNT_W  = $clog2(DEPTH + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               push,
   input  logic               pop,
   input  logic [ENTRY_W-1:0] wdata,
   output logic [ENTRY_W-1:0] rdata,
   output logic [CNT_W-1:0]   count
);
   logic [PTR_W-1:0]   wr_ptr_q, rd_ptr_q;
   logic [CNT_W-1:0]   count_q;
   logic [ENTRY_W-1:0] slot_view [DEPTH];

   if ((DEPTH & (DEPTH - 1)) != 0 || DEPTH < 2) begin : g_bad_depth
      $error("trc_fifo: DEPTH must be a power of two and at least 2");
   end

   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      logic [ENTRY_W-1:0] q;
      always_ff @(posedge clk) begin
         if (push && wr_ptr_q == PTR_W'(i)) q <= wdata;
      end
      assign slot_view[i] = q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr_q <= '0;
         rd_ptr_q <= '0;
         count_q  <= '0;
      end else begin
         if (push) wr_ptr_q <= wr_ptr_q + 1'b1;
         if (pop)  rd_ptr_q <= rd_ptr_q + 1'b1;
         case ({push, pop})
            2'b10:   count_q <= count_q + 1'b1;
            2'b01:   count_q <= count_q - 1'b1;
            default: count_q <= count_q;
         endcase
      end
   end

   assign rdata = slot_view[rd_ptr_q];
   assign count = count_q;

   assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (push && count_q == CNT_W'(DEPTH)) |-> pop);
   assert_no_underflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> (count_q != '0));
   assert_full_swap_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (count_q == CNT_W'(DEPTH) && push && pop) |=> (count_q == CNT_W'(DEPTH)));
endmodule

// File: rtl/trc_stall_ctl.sv
module trc_stall_ctl #(
   parameter int DEPTH   = 16,
   parameter int MARGIN  = 4,
   parameter int DROP_W  = 8,
   localparam int CNT_W  = $clog2(DEPTH + 1),
   localparam int THRESH = DEPTH - MARGIN
) (
   input  logic              clk,
   input  logic              rst_n,
   input  trc_pkg::buf_mode_e mode,
   input  logic [CNT_W-1:0]  count,
   input  logic              drop,
   output logic              stall_req,
   output logic [DROP_W-1:0] drop_cnt
);
   logic [DROP_W-1:0] drop_q;

   if (MARGIN < 1 || MARGIN >= DEPTH) begin : g_bad_margin
      $error("trc_stall_ctl: MARGIN must lie in 1 .. DEPTH-1");
   end

   assign stall_req = (mode == trc_pkg::MODE_STALL) && (count >= CNT_W'(THRESH));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    drop_q <= '0;
      else if (drop && drop_q != '1) drop_q <= drop_q + 1'b1;
   end

   assign drop_cnt = drop_q;

   assert_drop_sat_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (drop_q == '1) |=> (drop_q == '1));
   assert_drop_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !drop |=> $stable(drop_q));
endmodule

// File: rtl/trc_regs.sv
module trc_regs #(
   parameter int ADDR_W    = 4,
   parameter int BUS_W     = 32,
   parameter int DROP_W    = 8,
   parameter int CTRL_ADDR = 0,
   parameter int DROP_ADDR = 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic               bus_we,
   input  logic [BUS_W-1:0]   bus_wdata,
   output logic [BUS_W-1:0]   bus_rdata,
   input  logic               stall_req,
   input  logic               suspend_in,
   input  logic [DROP_W-1:0]  drop_cnt,
   output trc_pkg::buf_mode_e mode
);
   trc_pkg::buf_mode_e mode_q;
   logic hit_ctrl, hit_drop;

   if (BUS_W <= trc_pkg::STAT_BIT || BUS_W < DROP_W) begin : g_bad_bus
      $error("trc_regs: BUS_W too narrow for the register fields");
   end

   assign hit_ctrl = (bus_addr == ADDR_W'(CTRL_ADDR));
   assign hit_drop = (bus_addr == ADDR_W'(DROP_ADDR));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   mode_q <= trc_pkg::MODE_DISCARD;
      else if (bus_we && hit_ctrl)  mode_q <= trc_pkg::buf_mode_e'(bus_wdata[trc_pkg::MODE_BIT]);
   end

   always_comb begin
      bus_rdata = '0;
      if (hit_ctrl) begin
         bus_rdata[trc_pkg::MODE_BIT] = mode_q;
         bus_rdata[trc_pkg::STAT_BIT] = stall_req | suspend_in;
      end else if (hit_drop) begin
         bus_rdata[DROP_W-1:0] = drop_cnt;
      end
   end

   assign mode = mode_q;

   assert_mode_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_we && hit_ctrl) |=> $stable(mode_q));
endmodule

// File: rtl/trace_capture_buf.sv
module trace_capture_buf #(
   parameter int ENTRY_W   = 32,
   parameter int DEPTH     = 16,
   parameter int MARGIN    = 4,
   parameter int DROP_W    = 8,
   parameter int ADDR_W    = 4,
   parameter int BUS_W     = 32,
   parameter int CTRL_ADDR = 0,
   parameter int DROP_ADDR = 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               hit_valid,
   input  logic [ENTRY_W-1:0] hit_data,
   output logic               rd_valid,
   input  logic               rd_ready,
   output logic [ENTRY_W-1:0] rd_data,
   output logic               cpu_stall_req,
   input  logic               suspend_in,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic               bus_we,
   input  logic [BUS_W-1:0]   bus_wdata,
   output logic [BUS_W-1:0]   bus_rdata
);
   localparam int CNT_W  = $clog2(DEPTH + 1);
   localparam int THRESH = DEPTH - MARGIN;

   logic [CNT_W-1:0]   count;
   logic [DROP_W-1:0]  drop_cnt;
   logic               full, push, pop, drop, stall;
   trc_pkg::buf_mode_e mode;

   if (CTRL_ADDR == DROP_ADDR) begin : g_bad_map
      $error("trace_capture_buf: register offsets must differ");
   end

   assign full     = (count == CNT_W'(DEPTH));
   assign rd_valid = (count != '0);
   assign pop      = rd_valid && rd_ready;
   assign push     = hit_valid && (!full || pop);
   assign drop     = hit_valid && full && !pop;

   trc_fifo #(.ENTRY_W(ENTRY_W), .DEPTH(DEPTH)) u_fifo (
      .clk(clk), .rst_n(rst_n), .push(push), .pop(pop),
      .wdata(hit_data), .rdata(rd_data), .count(count)
   );

   trc_stall_ctl #(.DEPTH(DEPTH), .MARGIN(MARGIN), .DROP_W(DROP_W)) u_stall (
      .clk(clk), .rst_n(rst_n), .mode(mode), .count(count), .drop(drop),
      .stall_req(stall), .drop_cnt(drop_cnt)
   );

   trc_regs #(.ADDR_W(ADDR_W), .BUS_W(BUS_W), .DROP_W(DROP_W),
              .CTRL_ADDR(CTRL_ADDR), .DROP_ADDR(DROP_ADDR)) u_regs (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .stall_req(stall),
      .suspend_in(suspend_in), .drop_cnt(drop_cnt), .mode(mode)
   );

   assign cpu_stall_req = stall;

   assert_discard_no_stall_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == trc_pkg::MODE_DISCARD) |-> !cpu_stall_req);
   assert_stall_level_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == trc_pkg::MODE_STALL && count >= CNT_W'(THRESH)) |-> cpu_stall_req);
   assert_margin_no_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_valid && count < CNT_W'(DEPTH)) |=> (drop_cnt == $past(drop_cnt)));
   assert_drop_needs_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (drop_cnt != $past(drop_cnt)) |-> $past(hit_valid && full && !rd_ready));
endmodule

// File: tb/trace_capture_buf_test.sv
module trace_capture_buf_test;
   localparam int EW = 16, DEPTH = 8, MARGIN = 3, DW = 4, AW = 4, BW = 32;
   localparam int THRESH = DEPTH - MARGIN;
   localparam int DMAX = (1 << DW) - 1;

   logic clk = 1'b0, rst_n = 1'b0;
   logic hit_valid = 1'b0, rd_ready = 1'b0, suspend_in = 1'b0, bus_we = 1'b0;
   logic [EW-1:0] hit_data = '0;
   logic [AW-1:0] bus_addr = '0;
   logic [BW-1:0] bus_wdata = '0;
   logic rd_valid, cpu_stall_req;
   logic [EW-1:0] rd_data;
   logic [BW-1:0] bus_rdata;

   int n_chk = 0, n_fail = 0;
   logic [EW-1:0] mq[$];
   bit m_mode = 0;
   int m_drop = 0;

   always #5 clk = ~clk;

   trace_capture_buf #(.ENTRY_W(EW), .DEPTH(DEPTH), .MARGIN(MARGIN), .DROP_W(DW),
                       .ADDR_W(AW), .BUS_W(BW)) uut (
      .clk(clk), .rst_n(rst_n), .hit_valid(hit_valid), .hit_data(hit_data),
      .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
      .cpu_stall_req(cpu_stall_req), .suspend_in(suspend_in), .bus_addr(bus_addr),
      .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata));

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic bit exp_stall();
      return m_mode && (mq.size() >= THRESH);
   endfunction

   function automatic logic [BW-1:0] exp_rdata(input logic [AW-1:0] a, input bit su);
      logic [BW-1:0] r = '0;
      if (a == 0) begin
         r[8] = m_mode;
         r[9] = exp_stall() | su;
      end else if (a == 1) begin
         r[DW-1:0] = DW'(m_drop);
      end
      return r;
   endfunction

   // Drive one cycle at the falling edge, check outputs, then advance the model.
   task automatic step(input bit h, input logic [EW-1:0] d, input bit rdy, input bit we,
                       input logic [AW-1:0] a, input logic [BW-1:0] wd, input bit su);
      bit pop, full;
      hit_valid = h; hit_data = d; rd_ready = rdy; bus_we = we;
      bus_addr = a; bus_wdata = wd; suspend_in = su;
      #1;
      chk(rd_valid == (mq.size() != 0), "R7", "rd_valid", rd_valid, mq.size() != 0);
      if (mq.size() != 0) chk(rd_data == mq[0], "R7", "rd_data order", rd_data, mq[0]);
      chk(cpu_stall_req == exp_stall(), m_mode ? "R4" : "R3", "stall", cpu_stall_req, exp_stall());
      chk(bus_rdata == exp_rdata(a, su), (a == 1) ? "R9" : "R6", "bus_rdata",
          bus_rdata, exp_rdata(a, su));
      @(posedge clk);
      pop = rdy && mq.size() != 0;
      full = mq.size() == DEPTH;
      if (pop) void'(mq.pop_front());
      if (h) begin
         if (!full || pop) mq.push_back(d);
         else if (m_drop < DMAX) m_drop++;
      end
      if (we && a == 0) m_mode = wd[8];
      @(negedge clk);
   endtask

   task automatic idle(input logic [AW-1:0] a);
      step(0, '0, 0, 0, a, '0, 0);
   endtask

   initial begin
      #(10 * 200000);
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      int d0;
      void'($urandom(32'h5eed_1234));
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R1 reset state
      chk(rd_valid == 0, "R1", "rd_valid after reset", rd_valid, 0);
      chk(cpu_stall_req == 0, "R1", "stall after reset", cpu_stall_req, 0);
      chk(bus_rdata == 0, "R1", "ctrl reg after reset", bus_rdata, 0);
      bus_addr = 1; #1;
      chk(bus_rdata == 0, "R1", "drop count after reset", bus_rdata, 0);
      @(negedge clk);

      // R2 mode write/read; R6 status bit write ignored
      step(0, '0, 0, 1, 0, 32'h0000_0300, 0);
      idle(0);
      chk(bus_rdata[9] == 0, "R6", "status after write of bit 9", bus_rdata[9], 0);
      step(0, '0, 0, 1, 2, 32'h0, 0);           // write elsewhere: mode holds (R2)
      idle(0);
      chk(bus_rdata[8] == 1, "R2", "mode kept after write to other offset", bus_rdata[8], 1);
      step(0, '0, 0, 0, 0, '0, 1);              // R6 suspend visible
      step(0, '0, 0, 1, 0, 32'h0, 0);           // back to discard

      // R3 discard: fill past full, drops counted, no stall
      for (int i = 0; i < DEPTH + 3; i++) step(1, EW'(16'h100 + i), 0, 0, 1, '0, 0);
      chk(m_drop == 3, "R3", "model drops", m_drop, 3);
      idle(1);
      chk(bus_rdata == 3, "R3", "drop count after overflow", bus_rdata, 3);
      // R8 full swap
      step(1, 16'hABCD, 1, 0, 1, '0, 0);
      idle(1);
      chk(bus_rdata == 3, "R8", "no drop on full swap", bus_rdata, 3);
      for (int i = 0; i < DEPTH; i++) step(0, '0, 1, 0, 0, '0, 0);
      chk(rd_valid == 0, "R7", "drained", rd_valid, 0);

      // R4/R5 stall mode: fill to DEPTH, stall from THRESH, no drops in margin
      step(0, '0, 0, 1, 0, 32'h100, 0);
      d0 = m_drop;
      for (int i = 0; i < DEPTH; i++) step(1, EW'($urandom), 0, 0, 0, '0, 0);
      chk(cpu_stall_req == 1, "R4", "stall at full", cpu_stall_req, 1);
      idle(1);
      chk(bus_rdata == d0, "R5", "no drops within margin", bus_rdata, d0);
      for (int i = 0; i < MARGIN + 1; i++) step(0, '0, 1, 0, 0, '0, 0);
      chk(cpu_stall_req == 0, "R4", "stall released below threshold", cpu_stall_req, 0);
      for (int i = 0; i < THRESH - 1; i++) step(0, '0, 1, 0, 0, '0, 0);

      // R9 saturation
      step(0, '0, 0, 1, 0, 32'h0, 0);
      for (int i = 0; i < DEPTH + DMAX + 4; i++) step(1, EW'(i), 0, 0, 1, '0, 0);
      idle(1);
      chk(bus_rdata == DMAX, "R9", "drop count saturated", bus_rdata, DMAX);
      idle(3);
      chk(bus_rdata == 0, "R9", "unmapped offset", bus_rdata, 0);
      for (int i = 0; i < DEPTH; i++) step(0, '0, 1, 0, 0, '0, 0);

      // Random mix of hits, drains, mode changes and suspend
      for (int i = 0; i < 4000; i++) begin
         bit w = ($urandom_range(0, 49) == 0);
         step($urandom_range(0, 99) < 60, EW'($urandom), $urandom_range(0, 99) < 45,
              w, w ? AW'(0) : AW'($urandom_range(0, 3)),
              {23'h0, $urandom_range(0, 3) != 0 ? 1'b1 : 1'b0, 8'h0},
              $urandom_range(0, 9) == 0);
      end

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule